// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters. Each one turns a slow
reference strobe into a periodic output line. Software configures a channel in
two steps. First it writes a command byte, which picks the channel, the order in
which the preset bytes arrive and the output waveform. Then it writes one or two
data bytes, which form the preset. Counting moves only on cycles where the
count-enable input is high. That input is normally a strobe at the 1.193182 MHz
reference rate, taken from the system clock.

The usual setup sends a square wave from channel 0 to the periodic interrupt
request line. For that channel the command is 0x36, and the preset is the
reference rate divided by the wanted tick frequency. A channel can also run as
a rate generator. In that mode its output is high except for one low strobe
period in every cycle of the count. Decimal counting is not supported. The
decimal-select bit is accepted and has no effect on counting.

Top module: `interval_timer`

## Requirements
- R1: After reset all three output lines are high and every channel is idle until it is configured.
- R2: A command write uses address 3. Bits 7:6 of the byte give the channel, bits 5:4 the access mode and bits 3:1 the operating mode. Bit 0 is ignored, so counting is always binary. A command write stops the channel and holds its line high from the next cycle until a new preset has been loaded.
- R3: Access mode 11 takes two writes to the channel's data address, which is equal to the channel number: the low byte first, then the high byte. Counting starts only after the high byte. The line is high right after the load.
- R4: Access mode 01 loads the preset from a single low-byte write, with the high byte taken as zero. Access mode 10 loads it from a single high-byte write, with the low byte taken as zero.
- R5: Operating-mode bits 2:1 equal to 11 (values 3 and 7) select a square wave. The period is N enabled ticks. The line is high for the first ceil(N/2) ticks and low for the rest.
- R6: Operating-mode bits 2:1 equal to 10 (values 2 and 6) select a rate generator. The period is N ticks, and the line is low for exactly one tick when the count reaches 1. A preset of 1 keeps the line high.
- R7: A preset of 0 counts as 65536.
- R8: The counters change only on cycles where the count-enable input is high.
- R9: A write to one channel does not affect how the other channels count or what they output.
- R10: Any other operating mode (0, 1, 4, 5) leaves the channel stopped with its line high, even after a preset has been loaded.
- R11: A command byte that names channel 3, or that has access mode 00, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | 0 to 2 select a channel data register, 3 selects the command register |
| wrData | input | 8 | Write data byte |
| tickEn | input | 1 | Count-enable strobe from the reference rate |
| timerOut | output | 3 | One output line per channel |

## Verification
A write is taken at a rising edge. A command or a completed preset takes effect
at that same edge, so the affected line must be high when the bench samples it
at the next falling edge. Each enabled tick moves a count at one rising edge,
and the output follows from registered state with no further delay. The bench
therefore applies one tick per cycle and compares all three lines at every
falling edge against a model of each channel that counts ticks since its load.
Cycles where count-enable is low leave the model unchanged, and the lines must
not change either.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CH_NUM   = 3;
  localparam int BYTE_W   = 8;
  localparam int PRESET_W = 2 * BYTE_W;
  localparam int CNT_W    = PRESET_W + 1;
  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CH_NUM);

  localparam logic [1:0] OP_OFF    = 2'd0;
  localparam logic [1:0] OP_RATE   = 2'd1;
  localparam logic [1:0] OP_SQUARE = 2'd2;

  typedef struct packed {
    logic [CH_NUM-1:0]      load;
    logic [CH_NUM-1:0]      halt;
    logic [PRESET_W-1:0]    preset;
    logic [CH_NUM-1:0][1:0] mode;
  } ctrlStrobes_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wrData,
  output ctrlStrobes_t        strobes
);
  logic [CH_NUM-1:0][1:0]        accMode;
  logic [CH_NUM-1:0][1:0]        modeReg;
  logic [CH_NUM-1:0]             wantHigh;
  logic [CH_NUM-1:0][BYTE_W-1:0] lowByte;

  logic       cmdWr, cmdValid, dataWr;
  logic [1:0] cmdCh, cmdAcc, cmdMode;

  function automatic logic [1:0] decodeMode(input logic [1:0] f);
    case (f)
      2'b10:   return OP_RATE;
      2'b11:   return OP_SQUARE;
      default: return OP_OFF;
    endcase
  endfunction

  assign cmdWr    = wrEn && (addr == CMD_ADDR);
  assign dataWr   = wrEn && (addr != CMD_ADDR);
  assign cmdCh    = wrData[7:6];
  assign cmdAcc   = wrData[5:4];
  assign cmdMode  = decodeMode(wrData[2:1]);
  assign cmdValid = cmdWr && (cmdCh != 2'd3) && (cmdAcc != 2'b00);

  always_comb begin
    strobes      = '0;
    strobes.mode = modeReg;
    for (int ch = 0; ch < CH_NUM; ch++) begin
      strobes.halt[ch] = cmdValid && (cmdCh == 2'(ch));
      if (dataWr && (addr == ADDR_W'(ch))) begin
        case (accMode[ch])
          2'b01: begin
            strobes.preset   = {{BYTE_W{1'b0}}, wrData};
            strobes.load[ch] = 1'b1;
          end
          2'b10: begin
            strobes.preset   = {wrData, {BYTE_W{1'b0}}};
            strobes.load[ch] = 1'b1;
          end
          2'b11: begin
            strobes.preset   = {wrData, lowByte[ch]};
            strobes.load[ch] = wantHigh[ch];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode  <= '0;
      modeReg  <= '0;
      wantHigh <= '0;
      lowByte  <= '0;
    end else begin
      for (int ch = 0; ch < CH_NUM; ch++) begin
        if (strobes.halt[ch]) begin
          accMode[ch]  <= cmdAcc;
          modeReg[ch]  <= cmdMode;
          wantHigh[ch] <= 1'b0;
        end else if (dataWr && (addr == ADDR_W'(ch)) && (accMode[ch] == 2'b11)) begin
          if (!wantHigh[ch]) lowByte[ch] <= wrData;
          wantHigh[ch] <= !wantHigh[ch];
        end
      end
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctrlStrobes_t      strobes,
  output logic [CH_NUM-1:0] timerOut
);
  logic [CNT_W-1:0] loadVal;

  // A zero preset stands for the full 2^16 span.
  assign loadVal = (strobes.preset == '0) ? (CNT_W'(1) << PRESET_W)
                                          : {1'b0, strobes.preset};

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
    logic [CNT_W-1:0] count, reload;
    logic             running, active;

    assign active = running && (strobes.mode[ch] != OP_OFF);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        count   <= '0;
        reload  <= '0;
        running <= 1'b0;
      end else if (strobes.halt[ch]) begin
        running <= 1'b0;
      end else if (strobes.load[ch]) begin
        count   <= loadVal;
        reload  <= loadVal;
        running <= 1'b1;
      end else if (tickEn && active) begin
        count <= (count == CNT_W'(1)) ? reload : count - CNT_W'(1);
      end
    end

    always_comb begin
      if (!active) begin
        timerOut[ch] = 1'b1;
      end else begin
        case (strobes.mode[ch])
          OP_RATE:   timerOut[ch] = !((count == CNT_W'(1)) && (reload != CNT_W'(1)));
          OP_SQUARE: timerOut[ch] = count > (reload >> 1);
          default:   timerOut[ch] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              tickEn,
  output logic [CH_NUM-1:0] timerOut
);
  ctrlStrobes_t strobes;

  timer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .strobes (strobes)
  );

  timer_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strobes  (strobes),
    .timerOut (timerOut)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [3:0]             cmdSel,
  input logic                   tickEn,
  input logic [CH_NUM-1:0]      timerOut,
  input logic [CH_NUM-1:0]      loadStb,
  input logic [CH_NUM-1:0][1:0] modeStb
);
  logic cmdIgnored;
  assign cmdIgnored = wrEn && (addr == CMD_ADDR) &&
                      ((cmdSel[3:2] == 2'd3) || (cmdSel[1:0] == 2'b00));

  // R8: with no tick and no write, the lines hold
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable(timerOut));

  // R11: an ignored command changes nothing while no tick occurs
  a_r11_reserved_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIgnored && !tickEn) |=> $stable(timerOut));

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chk
    // R2: a valid command for this channel leaves its line high
    a_r2_cmd_halts: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && (addr == CMD_ADDR) && (cmdSel[3:2] == 2'(ch)) && (cmdSel[1:0] != 2'b00))
      |=> timerOut[ch]);

    // R3: a completed preset load starts with the line high
    a_r3_load_high: assert property (@(posedge clk) disable iff (!rstN)
      loadStb[ch] |=> timerOut[ch]);

    // R6: a rate-generator low lasts a single tick
    a_r6_single_low: assert property (@(posedge clk) disable iff (!rstN)
      ((modeStb[ch] == OP_RATE) && !timerOut[ch] && tickEn) |=> timerOut[ch]);

    // R10: an unsupported mode keeps the line high
    a_r10_off_high: assert property (@(posedge clk) disable iff (!rstN)
      (modeStb[ch] == OP_OFF) |-> timerOut[ch]);
  end
endmodule

bind interval_timer timer_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .cmdSel   (wrData[7:4]),
  .tickEn   (tickEn),
  .timerOut (timerOut),
  .loadStb  (strobes.load),
  .modeStb  (strobes.mode)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       tickEn = 1'b0;
  logic [2:0] timerOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Requirement model per channel: mode 0 off, 1 rate, 2 square
  int mRun[3], mMode[3], mN[3], mT[3], mAcc[3];

  interval_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .tickEn(tickEn), .timerOut(timerOut)
  );

  always #2.5 clk = ~clk;

  function automatic logic expOut(int c);
    int cnt;
    if (mRun[c] == 0 || mMode[c] == 0) return 1'b1;
    cnt = mN[c] - (mT[c] % mN[c]);
    if (mMode[c] == 1) return (mN[c] == 1) ? 1'b1 : (cnt != 1);
    return cnt > (mN[c] / 2);
  endfunction

  task automatic checkAll(string tag);
    for (int c = 0; c < 3; c++) begin
      logic e;
      e = expOut(c);
      nChecks++;
      if (timerOut[c] !== e) begin
        nFails++;
        $display("FAIL %s ch%0d got %b exp %b", tag, c, timerOut[c], e);
      end
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b, string tag);
    int ch;
    writeReg(2'd3, b);
    ch = int'(b[7:6]);
    if (ch != 3 && b[5:4] != 2'b00) begin
      mRun[ch] = 0;
      mAcc[ch] = int'(b[5:4]);
      mMode[ch] = (b[2:1] == 2'b10) ? 1 : (b[2:1] == 2'b11) ? 2 : 0;
    end
    checkAll(tag);
  endtask

  task automatic loadPreset(int ch, logic [15:0] n, string tag);
    int v;
    v = 0;
    case (mAcc[ch])
      3: begin
        writeReg(2'(ch), n[7:0]);
        checkAll("R3");
        writeReg(2'(ch), n[15:8]);
        v = int'(n);
      end
      1: begin writeReg(2'(ch), n[7:0]); v = int'(n[7:0]); end
      2: begin writeReg(2'(ch), n[15:8]); v = int'(n[15:8]) * 256; end
      default: ;
    endcase
    mRun[ch] = 1; mT[ch] = 0; mN[ch] = (v == 0) ? 65536 : v;
    checkAll(tag);
  endtask

  task automatic runTicks(int k, string tag);
    tickEn = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++)
        if (mRun[c] != 0 && mMode[c] != 0) mT[c]++;
      checkAll(tag);
    end
    tickEn = 1'b0;
  endtask

  task automatic holdIdle(int k, string tag);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      checkAll(tag);
    end
  endtask

  task automatic testReset();
    checkAll("R1");
    runTicks(4, "R1");
  endtask

  task automatic testSquareOdd();
    cmd(8'h36, "R2");
    writeReg(2'd0, 8'd5);
    runTicks(3, "R3");            // only low byte so far: stays high
    writeReg(2'd0, 8'd0);
    mRun[0] = 1; mT[0] = 0; mN[0] = 5;
    checkAll("R3");
    runTicks(12, "R5");
  endtask

  task automatic testRateGen();
    cmd(8'h74, "R9");             // ch1 rate gen, ch0 keeps running
    loadPreset(1, 16'd4, "R9");
    runTicks(13, "R6");
  endtask

  task automatic testSingleByte();
    cmd(8'h96, "R4");             // ch2 low byte only, square
    loadPreset(2, 16'h0006, "R4");
    runTicks(13, "R4");
    cmd(8'hA4, "R4");             // ch2 high byte only, rate gen
    loadPreset(2, 16'h0100, "R4");
    runTicks(260, "R4");
  endtask

  task automatic testPointerReset();
    cmd(8'h36, "R3");
    writeReg(2'd0, 8'd3);
    cmd(8'h36, "R3");             // pointer back to low byte
    loadPreset(0, 16'd7, "R3");
    runTicks(15, "R3");
  endtask

  task automatic testNoTick();
    holdIdle(6, "R8");
  endtask

  task automatic testBcdIgnored();
    cmd(8'h37, "R2");
    loadPreset(0, 16'd10, "R2");
    runTicks(21, "R2");
  endtask

  task automatic testUnsupported();
    cmd(8'h70, "R10");            // ch1 mode 0
    loadPreset(1, 16'd3, "R10");
    runTicks(6, "R10");
    cmd(8'h7A, "R10");            // ch1 mode 5
    loadPreset(1, 16'd3, "R10");
    runTicks(6, "R10");
  endtask

  task automatic testReserved();
    cmd(8'hF6, "R11");            // channel 3
    runTicks(5, "R11");
    cmd(8'h06, "R11");            // access 00 on ch0
    runTicks(7, "R11");
  endtask

  task automatic testZeroPreset();
    cmd(8'h74, "R7");
    loadPreset(1, 16'd0, "R7");
    runTicks(65540, "R7");
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      mRun[c] = 0; mMode[c] = 0; mN[c] = 1; mT[c] = 0; mAcc[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSquareOdd();
    testRateGen();
    testSingleByte();
    testPointerReset();
    testNoTick();
    testBcdIgnored();
    testUnsupported();
    testReserved();
    testZeroPreset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule